// File: doc/BRIEF.md
# Erase-Block Protection Controller

This block keeps the write-protection state of every erase block in a 71-block flash array. The array has 63 main blocks of 32 Kword and 8 parameter blocks of 4 Kword. Each block is in one of three states: unlocked, locked, or locked-down. Commands arrive as a one-cycle strobe with a 2-bit operation code and an address. The address is decoded to a block, and the command updates that block's state at the next clock edge. The decode takes into account whether the parameter blocks sit at the top or at the bottom of the address space.

A separate query address lets the program and erase path ask whether a block may be modified. The same query returns the block's two protection bits for signature reads. A write-protect pin decides whether lock-down is enforced. A program-voltage lockout input refuses every program and erase request, whatever the lock state. An erase or program that sees the permit flag low must abort and report an error.

Addresses are given as word-address bits 20 down to 12 (`cmdSel`, `qrySel`). These are the only bits that matter at 4 Kword block granularity.

Top module: `blk_lock_guard`

## Requirements
- R1: After reset, every block reads status 2'b01 (locked, not locked-down) and permit 0.
- R2: With parameter blocks at the top (default), a selector whose upper six bits are all ones picks one of 8 parameter blocks by its lower three bits. Any other selector picks the main block numbered by its upper six bits. A command affects every address of its block and no other block.
- R3: Opcode 2'b10 (unlock) clears the lock bit of the addressed block. Its status then reads 2'b00 and permit reads 1 while the lockout is inactive.
- R4: Opcode 2'b01 (lock) sets the lock bit of the addressed block, so status bit 0 reads 1 and permit reads 0.
- R5: Opcode 2'b11 (lock-down) sets both the lock bit and the lock-down bit, so status reads 2'b11.
- R6: While wpN is low, a block whose lock-down bit is set ignores lock, unlock and lock-down commands.
- R7: While wpN is high, a locked-down block may be unlocked (status 2'b10) and locked again, and its lock-down bit stays set.
- R8: The lock-down bit of a block is cleared only by reset.
- R9: While vppLow is high, permit reads 0 for every block, and the status bits are unaffected.
- R10: While cmdValid is low, and for opcode 2'b00, no block state changes.
- R11: A command's effect is visible on the query outputs in the cycle that follows the clock edge that accepted it. The query path is combinational from state and query address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; locks every block |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 2 | 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmdSel | input | 9 | Command word-address bits 20..12 |
| wpN | input | 1 | Write-protect; low enforces lock-down |
| vppLow | input | 1 | Program-voltage lockout active |
| qrySel | input | 9 | Query word-address bits 20..12 |
| qryPermit | output | 1 | Program/erase allowed on the queried block |
| qryStatus | output | 2 | Bit 1 locked-down, bit 0 locked, for the queried block |

## Verification
The hardest state to reach is a block that carries a lock-down bit but has its lock bit clear. Reaching it needs a lock-down command, then wpN raised, then an unlock. After that, wpN must drop again, and lock and lock-down commands must then be shown to bounce off that block. The directed stimulus walks this exact path and ends with a mid-run reset. A long random phase then mixes wpN, vppLow and opcodes over all 71 blocks, so that frozen and thawed blocks meet every command. A behavioural model, built on integer address arithmetic, is compared with both outputs every cycle.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LOCK   = 2'b01,
    OP_UNLOCK = 2'b10,
    OP_DOWN   = 2'b11
  } lockOp_t;

  // strobes from control to the state datapath
  typedef struct packed {
    logic setLock;
    logic clrLock;
    logic setDown;
  } lockStrobe_t;

endpackage

// File: rtl/blk_lock_decode.sv
module blk_lock_decode #(
  parameter int SEL_W     = 9,
  parameter int SUB_W     = 3,
  parameter int IDX_W     = 7,
  parameter bit PARAM_TOP = 1'b1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [IDX_W-1:0] idx
);
  localparam int SLOT_W     = SEL_W - SUB_W;
  localparam int MAIN_SLOTS = 2 ** SLOT_W;
  localparam int PARAM_CNT  = 2 ** SUB_W;

  logic [SLOT_W-1:0] slot;
  logic [SUB_W-1:0]  sub;

  assign slot = sel[SEL_W-1:SUB_W];
  assign sub  = sel[SUB_W-1:0];

  generate
    if (PARAM_TOP) begin : g_top
      // last main slot is split into the small blocks, numbered after the mains
      always_comb begin
        if (slot == SLOT_W'(MAIN_SLOTS - 1))
          idx = IDX_W'(MAIN_SLOTS - 1) + IDX_W'(sub);
        else
          idx = IDX_W'(slot);
      end
    end else begin : g_bot
      // first slot is split; small blocks take the lowest numbers
      always_comb begin
        if (slot == '0)
          idx = IDX_W'(sub);
        else
          idx = IDX_W'(slot) + IDX_W'(PARAM_CNT - 1);
      end
    end
  endgenerate

endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
#(
  parameter int SEL_W     = 9,
  parameter int SUB_W     = 3,
  parameter int IDX_W     = 7,
  parameter int BLK_CNT   = 71,
  parameter bit PARAM_TOP = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  lockOp_t          cmdOp,
  input  logic [SEL_W-1:0] cmdSel,
  input  logic [SEL_W-1:0] qrySel,
  output lockStrobe_t      strb,
  output logic [IDX_W-1:0] cmdIdx,
  output logic [IDX_W-1:0] qryIdx
);

  blk_lock_decode #(
    .SEL_W(SEL_W), .SUB_W(SUB_W), .IDX_W(IDX_W), .PARAM_TOP(PARAM_TOP)
  ) i_cmdDec (
    .sel(cmdSel),
    .idx(cmdIdx)
  );

  blk_lock_decode #(
    .SEL_W(SEL_W), .SUB_W(SUB_W), .IDX_W(IDX_W), .PARAM_TOP(PARAM_TOP)
  ) i_qryDec (
    .sel(qrySel),
    .idx(qryIdx)
  );

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      unique case (cmdOp)
        OP_LOCK:   strb.setLock = 1'b1;
        OP_UNLOCK: strb.clrLock = 1'b1;
        OP_DOWN:   strb.setDown = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (strb == '0));

  // R2
  cmd_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (int'(cmdIdx) < BLK_CNT));

  // R2
  qry_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(qryIdx) < BLK_CNT);

endmodule

// File: rtl/blk_lock_state.sv
module blk_lock_state
  import blk_lock_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int BLK_CNT = 71
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wpN,
  input  logic             vppLow,
  input  lockStrobe_t      strb,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic [IDX_W-1:0] qryIdx,
  output logic             permit,
  output logic [1:0]       status
);

  logic lockQ [BLK_CNT];
  logic downQ [BLK_CNT];

  generate
    for (genvar b = 0; b < BLK_CNT; b++) begin : g_blk
      logic hit;
      logic frozen;

      assign hit    = (cmdIdx == IDX_W'(b)) && (strb != '0);
      assign frozen = downQ[b] && !wpN;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lockQ[b] <= 1'b1;
          downQ[b] <= 1'b0;
        end else if (hit && !frozen) begin
          if (strb.setDown) begin
            lockQ[b] <= 1'b1;
            downQ[b] <= 1'b1;
          end else if (strb.setLock) begin
            lockQ[b] <= 1'b1;
          end else if (strb.clrLock) begin
            lockQ[b] <= 1'b0;
          end
        end
      end

      // R1
      reset_state_chk: assert property (@(posedge clk)
        $rose(rstN) |-> (lockQ[b] && !downQ[b]));

      // R8
      down_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
        downQ[b] |=> downQ[b]);

      // R6
      frozen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (downQ[b] && !wpN) |=> $stable(lockQ[b]));

      // R2
      untouched_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (cmdIdx != IDX_W'(b) || strb == '0) |=> ($stable(lockQ[b]) && $stable(downQ[b])));

      // R5
      down_implies_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(downQ[b]) |-> lockQ[b]);
    end
  endgenerate

  always_comb begin
    status = {downQ[qryIdx], lockQ[qryIdx]};
    permit = !lockQ[qryIdx] && !vppLow;
  end

endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
  import blk_lock_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int MAIN_LOG  = 15,
  parameter int PARAM_LOG = 12,
  parameter bit PARAM_TOP = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic [1:0]                  cmdOp,
  input  logic [ADDR_W-PARAM_LOG-1:0] cmdSel,
  input  logic                        wpN,
  input  logic                        vppLow,
  input  logic [ADDR_W-PARAM_LOG-1:0] qrySel,
  output logic                        qryPermit,
  output logic [1:0]                  qryStatus
);
  localparam int SEL_W   = ADDR_W - PARAM_LOG;
  localparam int SUB_W   = MAIN_LOG - PARAM_LOG;
  localparam int BLK_CNT = 2 ** (ADDR_W - MAIN_LOG) - 1 + 2 ** SUB_W;
  localparam int IDX_W   = $clog2(BLK_CNT);

  lockStrobe_t      strb;
  logic [IDX_W-1:0] cmdIdx;
  logic [IDX_W-1:0] qryIdx;

  blk_lock_ctrl #(
    .SEL_W(SEL_W), .SUB_W(SUB_W), .IDX_W(IDX_W),
    .BLK_CNT(BLK_CNT), .PARAM_TOP(PARAM_TOP)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .cmdValid(cmdValid),
    .cmdOp(lockOp_t'(cmdOp)),
    .cmdSel(cmdSel),
    .qrySel(qrySel),
    .strb(strb),
    .cmdIdx(cmdIdx),
    .qryIdx(qryIdx)
  );

  blk_lock_state #(
    .IDX_W(IDX_W), .BLK_CNT(BLK_CNT)
  ) i_state (
    .clk(clk),
    .rstN(rstN),
    .wpN(wpN),
    .vppLow(vppLow),
    .strb(strb),
    .cmdIdx(cmdIdx),
    .qryIdx(qryIdx),
    .permit(qryPermit),
    .status(qryStatus)
  );

  // R9
  lockout_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    vppLow |-> !qryPermit);

  // R3
  permit_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryPermit |-> !qryStatus[0]);

endmodule

// File: tb/test_blk_lock_guard.sv
`timescale 1ns/1ps
module test_blk_lock_guard;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [8:0] cmdSel = '0;
  logic       wpN = 1'b1;
  logic       vppLow = 1'b0;
  logic [8:0] qrySel = '0;
  logic       qryPermit;
  logic [1:0] qryStatus;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  bit  mLock [71];
  bit  mDown [71];

  always #4 clk = ~clk;

  blk_lock_guard i_blk_lock_guard (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSel(cmdSel), .wpN(wpN), .vppLow(vppLow), .qrySel(qrySel),
    .qryPermit(qryPermit), .qryStatus(qryStatus)
  );

  // word address -> block number, by plain arithmetic
  function automatic int refIdx(input int sel);
    int a;
    a = sel * 4096;
    if (a / 32768 < 63) return a / 32768;
    return 63 + (a % 32768) / 4096;
  endfunction

  function automatic logic [8:0] selOf(input int idx, input int off);
    if (idx < 63) return 9'((idx * 32768 + (off % 8) * 4096) / 4096);
    return 9'((63 * 32768 + (idx - 63) * 4096) / 4096);
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic compare(input string tag);
    int  qi;
    logic [1:0] expS;
    logic       expP;
    qi   = refIdx(int'(qrySel));
    expS = {mDown[qi], mLock[qi]};
    expP = !mLock[qi] && !vppLow;
    checks++;
    if (qryStatus !== expS) begin
      fails++;
      $display("FAIL %s status blk %0d: got %b exp %b", tag, qi, qryStatus, expS);
    end
    checks++;
    if (qryPermit !== expP) begin
      fails++;
      $display("FAIL %s permit blk %0d: got %b exp %b", tag, qi, qryPermit, expP);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cmdValid = 1'b0;
    for (int i = 0; i < 71; i++) begin mLock[i] = 1'b1; mDown[i] = 1'b0; end
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive at negedge, model at posedge, compare at next negedge (R11)
  task automatic step(input bit v, input int op, input int idx, input int off,
                      input bit wp, input bit vpp, input int qIdx, input int qOff,
                      input string tag);
    int bi;
    cmdValid = v;
    cmdOp    = 2'(op);
    cmdSel   = selOf(idx, off);
    wpN      = wp;
    vppLow   = vpp;
    qrySel   = selOf(qIdx, qOff);
    @(posedge clk);
    bi = refIdx(int'(cmdSel));
    if (v && op != 0 && !(mDown[bi] && !wp)) begin
      if (op == 1) mLock[bi] = 1'b1;
      else if (op == 2) mLock[bi] = 1'b0;
      else begin mLock[bi] = 1'b1; mDown[bi] = 1'b1; end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic peek(input int qIdx, input int qOff, input bit wp, input bit vpp,
                      input string tag);
    step(1'b0, 0, 0, 0, wp, vpp, qIdx, qOff, tag);
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // R1 every block locked after reset
    for (int b = 0; b < 71; b++) peek(b, b, 1'b1, 1'b0, "R1");

    // R3 unlock main block 5 through one address, read through another
    step(1'b1, 2, 5, 3, 1'b1, 1'b0, 5, 0, "R3");
    peek(5, 7, 1'b1, 1'b0, "R3 R11");
    // R2 neighbours untouched
    peek(4, 7, 1'b1, 1'b0, "R2");
    peek(6, 0, 1'b1, 1'b0, "R2");
    // R2 parameter block region
    step(1'b1, 2, 65, 0, 1'b1, 1'b0, 65, 0, "R2 R3");
    peek(64, 0, 1'b1, 1'b0, "R2");
    peek(66, 0, 1'b1, 1'b0, "R2");
    peek(62, 7, 1'b1, 1'b0, "R2");
    // R4 lock again
    step(1'b1, 1, 65, 0, 1'b1, 1'b0, 65, 0, "R4");
    // R10 no valid strobe, no-op opcode
    step(1'b0, 2, 10, 0, 1'b1, 1'b0, 10, 0, "R10");
    step(1'b1, 0, 10, 0, 1'b1, 1'b0, 10, 0, "R10");
    // R5 lock-down
    step(1'b1, 3, 20, 2, 1'b1, 1'b0, 20, 5, "R5");
    // R6 frozen while wpN low
    step(1'b1, 2, 20, 0, 1'b0, 1'b0, 20, 0, "R6");
    // R7 thawed while wpN high
    step(1'b1, 2, 20, 0, 1'b1, 1'b0, 20, 0, "R7");
    step(1'b1, 1, 20, 0, 1'b1, 1'b0, 20, 0, "R7");
    step(1'b1, 2, 20, 0, 1'b1, 1'b0, 20, 0, "R7 R8");
    // R6 locked-down but unlocked block refuses lock and lock-down with wpN low
    step(1'b1, 1, 20, 0, 1'b0, 1'b0, 20, 0, "R6");
    step(1'b1, 3, 20, 0, 1'b0, 1'b0, 20, 0, "R6");
    // R9 lockout refuses everything, status intact
    peek(5, 0, 1'b1, 1'b1, "R9");
    peek(20, 0, 1'b0, 1'b1, "R9");
    peek(5, 0, 1'b1, 1'b0, "R9");
    // R8 only reset clears lock-down
    doReset();
    peek(20, 0, 1'b1, 1'b0, "R8 R1");
    peek(5, 0, 1'b1, 1'b0, "R1");

    // mixed random phase
    for (int n = 0; n < 4000; n++) begin
      step(1'(($urandom % 4) != 0), int'($urandom % 4), int'($urandom % 71),
           int'($urandom % 8), 1'(($urandom % 3) != 0), 1'(($urandom % 5) == 0),
           int'($urandom % 71), int'($urandom % 8), "R6 R7 R9 mix");
    end

    done = 1;
    report();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      report();
      $finish;
    end
  end

endmodule